// File: doc/BRIEF.md
# Dual-Channel Prescaled PWM Generator

This block produces two independent pulse-width-modulated outputs. Each channel picks one of several single-cycle tick strobes that live in the system clock domain, slows it with its own gated prescaler, and then plays a fixed two-phase waveform on its output. The high phase lasts a programmed number of prescaled ticks and the low phase lasts another programmed number. The waveform repeats until software clears the channel's enable.

Software sets the block up through a word-wide register port with three registers. There is one count word per channel, holding that channel's high and low lengths. One shared control word holds each channel's output enable, tick source select, prescaler value and prescaler gate. The block has no polarity control, so an inverted waveform is obtained by swapping the two lengths. The low phase never vanishes entirely: a low length of zero still yields one low tick per period. A high length of zero keeps the output low.

Top module: `twin_pwm`

## Requirements
- R1: After reset every register reads zero and both `pwm_out` bits are low.
- R2: Register map, by byte address:
  - 0x0 holds channel 0's count word and 0x4 holds channel 1's. In each, bits [31:16] are the high length and bits [15:0] are the low length.
  - 0x8 is the control word. For channel c: enable at bit c, source select at bits [5+2c:4+2c], prescaler value at bits [14+8c:8+8c], prescaler gate at bit 15+8c.
  - Control bits outside these fields read zero, so a write of all ones reads back 0x00FFFFF3.
  - Any other address reads zero, and writes to it change nothing.
- R3: A source select of s takes `src_tick[s]`. A prescaler value N passes every (N+1)-th selected tick to the channel counter.
- R4: While a channel's prescaler gate is clear, its counter receives no ticks and its output holds its level.
- R5: Clearing a channel's enable drives its output low on the clock edge that writes the control word, mid-period or not.
- R6: Setting a channel's enable starts its high phase. The output is high from the edge after the write. It then stays high for H prescaled ticks, goes low for L prescaled ticks, and repeats.
- R7: With L = 0 and H > 0, the output still goes low for exactly one prescaled tick each period.
- R8: With H = 0, the output stays low while the channel is enabled.
- R9: A count word written while its channel runs takes effect at the next period boundary; the current period finishes with the old lengths.
- R10: The two channels run independently, each with its own source, prescaler and lengths.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Write strobe for the register port |
| reg_addr | input | ADDR_W | Byte address for reads and writes |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for `reg_addr`, combinational |
| src_tick | input | N_SRC | Single-cycle tick strobes, one per selectable source |
| pwm_out | output | 2 | Channel waveforms, bit c for channel c |

## Verification
The bench targets the following corner cases and the fault each one would expose:
- A zero low length: a design that honoured it literally would stick high.
- A zero high length: a design that emitted one stray high tick would show a spike.
- A disable that arrives mid-high-phase: a design that finished the period first would leave the output high too long.
- A count write during a running period: a design without shadow lengths would cut the current period short, or stretch it.
- Slow tick sources combined with non-zero prescaler values: an off-by-one divider would show up as wrong run lengths.
- A closed prescaler gate: a leaky gate would let the output keep toggling.

// File: rtl/twinpwm_pkg.sv
`timescale 1ns/1ps
package twinpwm_pkg;
   localparam int NUM_CH     = 2;
   localparam int SEL_FLD_W  = 2;
   localparam int DIV_FLD_W  = 7;
   localparam int SPAN_FLD_W = 16;
   localparam int CTRL_OFF   = 8;

   typedef enum logic {PH_HIGH = 1'b0, PH_LOW = 1'b1} wave_phase_e;

   // Field positions inside the shared control word; software decodes these.
   function automatic int en_bit(int ch);   return ch;           endfunction
   function automatic int sel_lsb(int ch);  return 4 + 2 * ch;   endfunction
   function automatic int div_lsb(int ch);  return 8 + 8 * ch;   endfunction
   function automatic int gate_bit(int ch); return 15 + 8 * ch;  endfunction
   function automatic int span_off(int ch); return 4 * ch;       endfunction
endpackage

// File: rtl/twinpwm_regs.sv
`timescale 1ns/1ps
module twinpwm_regs
   import twinpwm_pkg::*;
#(
   parameter int ADDR_W = 4,
   parameter int CNT_W  = 16,
   parameter int DIV_W  = 7
) (
   input  logic                                     clk,
   input  logic                                     rst_n,
   input  logic                                     reg_wr,
   input  logic [ADDR_W-1:0]                        reg_addr,
   input  logic [31:0]                              reg_wdata,
   output logic [31:0]                              reg_rdata,
   output logic [NUM_CH-1:0]                        ch_en,
   output logic [NUM_CH-1:0][SEL_FLD_W-1:0]         ch_sel,
   output logic [NUM_CH-1:0][DIV_W-1:0]             ch_div,
   output logic [NUM_CH-1:0]                        ch_gate,
   output logic [NUM_CH-1:0][CNT_W-1:0]             ch_hi,
   output logic [NUM_CH-1:0][CNT_W-1:0]             ch_lo
);
   function automatic logic [31:0] ctrl_mask();
      logic [31:0] m = '0;
      for (int c = 0; c < NUM_CH; c++) begin
         m[en_bit(c)] = 1'b1;
         for (int i = 0; i < SEL_FLD_W; i++) m[sel_lsb(c) + i] = 1'b1;
         for (int i = 0; i < DIV_W; i++)     m[div_lsb(c) + i] = 1'b1;
         m[gate_bit(c)] = 1'b1;
      end
      return m;
   endfunction

   localparam logic [31:0] CTRL_MASK = ctrl_mask();

   logic [31:0]      ctrl_q;
   logic [CNT_W-1:0] hi_q [NUM_CH];
   logic [CNT_W-1:0] lo_q [NUM_CH];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ctrl_q <= '0;
         for (int c = 0; c < NUM_CH; c++) begin
            hi_q[c] <= '0;
            lo_q[c] <= '0;
         end
      end else if (reg_wr) begin
         if (reg_addr == ADDR_W'(CTRL_OFF)) ctrl_q <= reg_wdata & CTRL_MASK;
         for (int c = 0; c < NUM_CH; c++) begin
            if (reg_addr == ADDR_W'(span_off(c))) begin
               lo_q[c] <= reg_wdata[CNT_W-1:0];
               hi_q[c] <= reg_wdata[SPAN_FLD_W +: CNT_W];
            end
         end
      end
   end

   always_comb begin
      reg_rdata = '0;
      if (reg_addr == ADDR_W'(CTRL_OFF)) reg_rdata = ctrl_q;
      for (int c = 0; c < NUM_CH; c++) begin
         if (reg_addr == ADDR_W'(span_off(c)))
            reg_rdata = (32'(hi_q[c]) << SPAN_FLD_W) | 32'(lo_q[c]);
      end
   end

   for (genvar gc = 0; gc < NUM_CH; gc++) begin : g_fields
      localparam int EB = en_bit(gc);
      localparam int SL = sel_lsb(gc);
      localparam int DL = div_lsb(gc);
      localparam int GB = gate_bit(gc);
      assign ch_en[gc]   = ctrl_q[EB];
      assign ch_sel[gc]  = ctrl_q[SL +: SEL_FLD_W];
      assign ch_div[gc]  = ctrl_q[DL +: DIV_W];
      assign ch_gate[gc] = ctrl_q[GB];
      assign ch_hi[gc]   = hi_q[gc];
      assign ch_lo[gc]   = lo_q[gc];
   end
endmodule

// File: rtl/twinpwm_prescale.sv
`timescale 1ns/1ps
module twinpwm_prescale
   import twinpwm_pkg::*;
#(
   parameter int N_SRC = 4,
   parameter int DIV_W = 7
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic [N_SRC-1:0]     src_tick,
   input  logic [SEL_FLD_W-1:0] sel,
   input  logic [DIV_W-1:0]     div,
   input  logic                 gate,
   output logic                 ptick
);
   logic             tick_sel;
   logic [DIV_W-1:0] cnt_q;
   logic             terminal;

   // Selects beyond the populated sources see no ticks.
   always_comb begin
      tick_sel = 1'b0;
      for (int i = 0; i < N_SRC; i++)
         if (sel == SEL_FLD_W'(i)) tick_sel = src_tick[i];
   end

   assign terminal = (cnt_q >= div);
   assign ptick    = gate & tick_sel & terminal;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)         cnt_q <= '0;
      else if (!gate)     cnt_q <= '0;
      else if (tick_sel)  cnt_q <= terminal ? '0 : cnt_q + 1'b1;
   end

   // R3: back-to-back prescaled ticks only when the divider passes every tick
   p_div_spacing_r3 : assert property (@(posedge clk) disable iff (!rst_n)
      (ptick && $past(ptick) && $stable(div) && $past(gate)) |-> (div == '0));
endmodule

// File: rtl/twinpwm_wave.sv
`timescale 1ns/1ps
module twinpwm_wave
   import twinpwm_pkg::*;
#(
   parameter int CNT_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             en,
   input  logic             ptick,
   input  logic [CNT_W-1:0] hi_in,
   input  logic [CNT_W-1:0] lo_in,
   output logic             wave
);
   wave_phase_e      phase_q;
   logic             run_q;
   logic [CNT_W-1:0] cnt_q, hi_sh, lo_sh, lo_eff;
   logic [CNT_W:0]   cnt_nx;

   assign lo_eff = (lo_sh == '0) ? CNT_W'(1) : lo_sh;
   assign cnt_nx = {1'b0, cnt_q} + 1'b1;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         run_q <= 1'b0; phase_q <= PH_HIGH; cnt_q <= '0; hi_sh <= '0; lo_sh <= '0;
      end else if (!en) begin
         run_q <= 1'b0; phase_q <= PH_HIGH; cnt_q <= '0;
      end else if (!run_q) begin
         run_q   <= 1'b1;
         hi_sh   <= hi_in;
         lo_sh   <= lo_in;
         cnt_q   <= '0;
         phase_q <= (hi_in == '0) ? PH_LOW : PH_HIGH;
      end else if (ptick) begin
         if (phase_q == PH_HIGH) begin
            if (cnt_nx >= {1'b0, hi_sh}) begin
               phase_q <= PH_LOW; cnt_q <= '0;
            end else cnt_q <= cnt_nx[CNT_W-1:0];
         end else begin
            if (cnt_nx >= {1'b0, lo_eff}) begin
               hi_sh   <= hi_in;
               lo_sh   <= lo_in;
               cnt_q   <= '0;
               phase_q <= (hi_in == '0) ? PH_LOW : PH_HIGH;
            end else cnt_q <= cnt_nx[CNT_W-1:0];
         end
      end
   end

   assign wave = en & run_q & (phase_q == PH_HIGH);

   // R6: the high-phase count never reaches the latched high length
   p_hi_bound_r6 : assert property (@(posedge clk) disable iff (!rst_n)
      (run_q && phase_q == PH_HIGH) |-> (cnt_q < hi_sh));
   // R7: the low phase never exceeds its effective length of at least one
   p_lo_bound_r7 : assert property (@(posedge clk) disable iff (!rst_n)
      (run_q && phase_q == PH_LOW) |-> (cnt_q < lo_eff));
   // R8: a zero high length never shows a high level
   p_hi_zero_r8 : assert property (@(posedge clk) disable iff (!rst_n)
      (run_q && hi_sh == '0) |-> !wave);
   // R4: with no prescaled tick a running channel's position is frozen
   p_frozen_r4 : assert property (@(posedge clk) disable iff (!rst_n)
      (run_q && $past(run_q) && $past(en) && !$past(ptick)) |-> ($stable(cnt_q) && $stable(phase_q)));
endmodule

// File: rtl/twin_pwm.sv
`timescale 1ns/1ps
module twin_pwm
   import twinpwm_pkg::*;
#(
   parameter int ADDR_W = 4,
   parameter int CNT_W  = 16,
   parameter int DIV_W  = 7,
   parameter int N_SRC  = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              reg_wr,
   input  logic [ADDR_W-1:0] reg_addr,
   input  logic [31:0]       reg_wdata,
   output logic [31:0]       reg_rdata,
   input  logic [N_SRC-1:0]  src_tick,
   output logic [1:0]        pwm_out
);
   if (CNT_W < 1 || CNT_W > SPAN_FLD_W) begin : g_bad_cnt_w
      $error("twin_pwm: CNT_W must lie in 1..16");
   end
   if (DIV_W < 1 || DIV_W > DIV_FLD_W) begin : g_bad_div_w
      $error("twin_pwm: DIV_W must lie in 1..7");
   end
   if (N_SRC < 1 || N_SRC > (1 << SEL_FLD_W)) begin : g_bad_n_src
      $error("twin_pwm: N_SRC must lie in 1..4");
   end
   if (ADDR_W < 4) begin : g_bad_addr_w
      $error("twin_pwm: ADDR_W must be at least 4");
   end

   logic [NUM_CH-1:0]                ch_en, ch_gate;
   logic [NUM_CH-1:0][SEL_FLD_W-1:0] ch_sel;
   logic [NUM_CH-1:0][DIV_W-1:0]     ch_div;
   logic [NUM_CH-1:0][CNT_W-1:0]     ch_hi, ch_lo;

   twinpwm_regs #(.ADDR_W(ADDR_W), .CNT_W(CNT_W), .DIV_W(DIV_W)) u_regs (
      .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
      .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
      .ch_en(ch_en), .ch_sel(ch_sel), .ch_div(ch_div), .ch_gate(ch_gate),
      .ch_hi(ch_hi), .ch_lo(ch_lo)
   );

   for (genvar gc = 0; gc < NUM_CH; gc++) begin : g_chan
      logic ptick;

      twinpwm_prescale #(.N_SRC(N_SRC), .DIV_W(DIV_W)) u_pre (
         .clk(clk), .rst_n(rst_n), .src_tick(src_tick), .sel(ch_sel[gc]),
         .div(ch_div[gc]), .gate(ch_gate[gc]), .ptick(ptick)
      );

      twinpwm_wave #(.CNT_W(CNT_W)) u_wave (
         .clk(clk), .rst_n(rst_n), .en(ch_en[gc]), .ptick(ptick),
         .hi_in(ch_hi[gc]), .lo_in(ch_lo[gc]), .wave(pwm_out[gc])
      );

      // R5: a cleared enable in the control word means a low output
      p_off_low_r5 : assert property (@(posedge clk) disable iff (!rst_n)
         !ch_en[gc] |-> !pwm_out[gc]);
   end
endmodule

// File: tb/twin_pwm_tb.sv
`timescale 1ns/1ps
module twin_pwm_tb;
   localparam int CLK_PERIOD = 10;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        reg_wr = 1'b0;
   logic [3:0]  reg_addr = '0;
   logic [31:0] reg_wdata = '0;
   logic [31:0] reg_rdata;
   logic [3:0]  src_tick = '0;
   logic [1:0]  pwm_out;

   int n_checks = 0, n_fail = 0, cyc = 0;
   bit done = 0;

   // scoreboard state, one set per channel
   int    qa[$], qb[$];
   int    arm_cnt[2], run[2];
   bit    armed[2];
   bit    prev_l[2];
   string cur_tag[2];

   twin_pwm u_dut (.clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
                   .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
                   .src_tick(src_tick), .pwm_out(pwm_out));

   always #(CLK_PERIOD/2) clk = ~clk;

   // tick sources: every cycle, every 2nd, every 3rd, never
   initial forever begin
      @(negedge clk);
      cyc++;
      src_tick = {1'b0, (cyc % 3) == 0, (cyc % 2) == 0, 1'b1};
   end

   task automatic check(bit ok, string tag, string what, int got, int exp);
      n_checks++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s %s: actual=%0d expected=%0d", tag, what, got, exp);
      end
   endtask

   // monitor: measures run lengths and compares against queued expectations
   always @(negedge clk) begin
      if (rst_n) begin
         for (int c = 0; c < 2; c++) begin
            if (pwm_out[c] != prev_l[c]) begin
               if (armed[c]) begin
                  int item;
                  if (c == 0) item = qa.pop_front(); else item = qb.pop_front();
                  check(prev_l[c] == item[0], cur_tag[c], $sformatf("ch%0d run level", c),
                        int'(prev_l[c]), item % 2);
                  check(run[c] == item / 2, cur_tag[c], $sformatf("ch%0d run length", c),
                        run[c], item / 2);
                  if ((c == 0 ? qa.size() : qb.size()) == 0) armed[c] = 0;
               end
               if (pwm_out[c] && arm_cnt[c] > 0) begin
                  arm_cnt[c]--;
                  if (arm_cnt[c] == 0) armed[c] = 1;
               end
               prev_l[c] = pwm_out[c];
               run[c] = 1;
            end else run[c]++;
         end
      end
   end

   // driver: pushes expected high/low runs, arms the monitor at the second rise
   task automatic expect_runs(int ch, int h, int l, int p, int reps, string tag);
      int le = (l == 0) ? 1 : l;
      bit ok = 0;
      #1;
      cur_tag[ch] = tag;
      for (int r = 0; r < reps; r++) begin
         if (ch == 0) begin qa.push_back(h*p*2 + 1); qa.push_back(le*p*2); end
         else         begin qb.push_back(h*p*2 + 1); qb.push_back(le*p*2); end
      end
      arm_cnt[ch] = 2;
      for (int k = 0; k < 20000; k++) begin
         @(negedge clk);
         if (arm_cnt[ch] == 0 && !armed[ch]) begin ok = 1; break; end
      end
      check(ok, tag, $sformatf("ch%0d expected runs completed", ch), int'(ok), 1);
      if (!ok) begin
         arm_cnt[ch] = 0; armed[ch] = 0;
         if (ch == 0) qa.delete(); else qb.delete();
      end
   endtask

   task automatic wr(logic [3:0] a, logic [31:0] d);
      @(negedge clk);
      reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
      @(negedge clk);
      reg_wr = 1'b0;
   endtask

   task automatic rd(logic [3:0] a, output logic [31:0] d);
      @(negedge clk);
      reg_addr = a;
      #1 d = reg_rdata;
   endtask

   function automatic logic [31:0] cfg(int ch, bit en, int sel, int dv, bit gate);
      logic [31:0] v = '0;
      v[ch] = en;
      v[4+2*ch +: 2] = sel[1:0];
      v[8+8*ch +: 7] = dv[6:0];
      v[15+8*ch] = gate;
      return v;
   endfunction

   function automatic logic [31:0] span(int h, int l);
      return {h[15:0], l[15:0]};
   endfunction

   task automatic wait_level(int ch, bit lvl);
      for (int k = 0; k < 5000; k++) begin
         @(negedge clk);
         if (pwm_out[ch] == lvl) break;
      end
   endtask

   task automatic run_len(int ch, bit lvl, output int n);
      n = 1;
      for (int k = 0; k < 5000; k++) begin
         @(negedge clk);
         if (pwm_out[ch] == lvl) n++; else break;
      end
   endtask

   task automatic summary();
      $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
   endtask

   initial begin
      #(CLK_PERIOD * 150000);
      if (!done) begin
         n_fail++;
         $display("FAIL watchdog: actual=timeout expected=finished");
         summary();
         $finish;
      end
   end

   initial begin
      logic [31:0] d;
      int n, highs;
      bit same;
      repeat (3) @(negedge clk);
      check(pwm_out == 2'b00, "R1", "outputs in reset", int'(pwm_out), 0);
      rst_n = 1'b1;

      // R1: reset values
      rd(4'h0, d); check(d == 0, "R1", "count word 0 after reset", d, 0);
      rd(4'h4, d); check(d == 0, "R1", "count word 1 after reset", d, 0);
      rd(4'h8, d); check(d == 0, "R1", "control after reset", d, 0);
      check(pwm_out == 2'b00, "R1", "outputs after reset", int'(pwm_out), 0);

      // R2: register map
      wr(4'h8, 32'hFFFF_FFFF);
      rd(4'h8, d); check(d == 32'h00FF_FFF3, "R2", "control writable mask", d, 32'h00FF_FFF3);
      wr(4'h8, 32'h0);
      wr(4'h4, 32'h1234_5678);
      rd(4'h4, d); check(d == 32'h1234_5678, "R2", "count word 1 readback", d, 32'h1234_5678);
      wr(4'hC, 32'hDEAD_BEEF);
      rd(4'hC, d); check(d == 0, "R2", "unmapped address reads zero", d, 0);
      rd(4'h4, d); check(d == 32'h1234_5678, "R2", "unmapped write left count intact", d, 32'h1234_5678);
      rd(4'h8, d); check(d == 0, "R2", "unmapped write left control intact", d, 0);

      // R6: enable starts the high phase on the following edge
      wr(4'h0, span(3, 2));
      wr(4'h8, cfg(0, 1, 0, 0, 1));
      check(pwm_out[0] == 0, "R6", "ch0 low in write cycle", pwm_out[0], 0);
      @(negedge clk);
      check(pwm_out[0] == 1, "R6", "ch0 high one edge after enable", pwm_out[0], 1);
      expect_runs(0, 3, 2, 1, 3, "R6");

      // R10: channel 1 runs alongside, with its own source and divider
      wr(4'h4, span(2, 4));
      wr(4'h8, cfg(0, 1, 0, 0, 1) | cfg(1, 1, 1, 1, 1));
      fork
         expect_runs(0, 3, 2, 1, 3, "R10");
         expect_runs(1, 2, 4, 4, 3, "R10");
      join
      wr(4'h8, cfg(0, 1, 0, 0, 1));

      // R5: disable in the middle of a long high phase
      wr(4'h0, span(20, 20));
      repeat (30) @(negedge clk);
      wait_level(0, 0);
      wait_level(0, 1);
      wr(4'h8, cfg(0, 0, 0, 0, 1));
      check(pwm_out[0] == 0, "R5", "ch0 low right after disable", pwm_out[0], 0);
      highs = 0;
      repeat (25) begin @(negedge clk); highs += pwm_out[0]; end
      check(highs == 0, "R5", "ch0 stays low while disabled", highs, 0);

      // R3: slower source and prescaler values
      wr(4'h0, span(2, 1));
      wr(4'h8, cfg(0, 1, 2, 1, 1));
      expect_runs(0, 2, 1, 6, 2, "R3");
      wr(4'h8, 32'h0);
      wr(4'h0, span(3, 2));
      wr(4'h8, cfg(0, 1, 0, 2, 1));
      expect_runs(0, 3, 2, 3, 2, "R3");
      wr(4'h8, 32'h0);

      // R7: zero low length still gives one low tick
      wr(4'h0, span(2, 0));
      wr(4'h8, cfg(0, 1, 0, 0, 1));
      expect_runs(0, 2, 0, 1, 3, "R7");
      wr(4'h8, 32'h0);

      // R8: zero high length keeps the output low
      wr(4'h0, span(0, 3));
      wr(4'h8, cfg(0, 1, 0, 0, 1));
      highs = 0;
      repeat (60) begin @(negedge clk); highs += pwm_out[0]; end
      check(highs == 0, "R8", "ch0 high cycles with zero high length", highs, 0);
      wr(4'h8, 32'h0);

      // R9: count change mid-period waits for the period boundary
      wr(4'h0, span(4, 4));
      wr(4'h8, cfg(0, 1, 0, 0, 1));
      wait_level(0, 0);
      wait_level(0, 1);
      wr(4'h0, span(1, 1));
      wait_level(0, 0);
      run_len(0, 0, n); check(n == 4, "R9", "old low length finishes", n, 4);
      run_len(0, 1, n); check(n == 1, "R9", "new high length", n, 1);
      run_len(0, 0, n); check(n == 1, "R9", "new low length", n, 1);
      wr(4'h8, 32'h0);

      // R4: closed gate freezes the output
      wr(4'h0, span(5, 5));
      wr(4'h8, cfg(0, 1, 0, 0, 1));
      wait_level(0, 0);
      wait_level(0, 1);
      wr(4'h8, cfg(0, 1, 0, 0, 0));
      same = 1;
      repeat (30) begin @(negedge clk); if (pwm_out[0] != 1'b1) same = 0; end
      check(same, "R4", "ch0 held high with gate closed", int'(same), 1);
      wr(4'h8, cfg(0, 1, 0, 0, 1));
      highs = 0;
      repeat (30) begin @(negedge clk); highs += !pwm_out[0]; end
      check(highs > 0, "R4", "ch0 toggles again after gate reopens", highs > 0, 1);

      done = 1;
      summary();
      $finish;
   end
endmodule